// File: doc/BRIEF.md
# I2C Slave Address Recognizer with General Call

This block is the address-phase front end of an I2C slave. It oversamples the bus clock and data lines with the system clock, spots Start and Stop conditions, shifts in the first byte after a Start (most significant bit first) and decides whether this slave is addressed. It answers to a programmable 7-bit own address and, when enabled, to the all-zero broadcast byte (general call). General call is always a write to the slave.

On a match the block pulls the data line low through an open-drain enable for the whole ninth clock. It copies the byte into a receive buffer and raises a buffer-full flag while the eighth clock is still high. It updates three status flags: broadcast, address/data and read/write. It then fires a one-cycle interrupt when the ninth clock falls, and waits for the master to send data. Software reads the broadcast flag to tell a device-specific hit from a general call. When the slave is set for 10-bit addressing, the 7-bit own-address compare is turned off, but the broadcast byte is still recognized.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: Both bus lines pass through a two-stage synchronizer. SDA falling while SCL is high is a Start, and SDA rising while SCL is high is a Stop. After a Start, eight bits are sampled on SCL rising edges, the first bit landing in byte bit 7.
- R2: With gcEnable=1, a first byte of 0x00 is acknowledged: sdaDriveLow is 1 throughout the ninth SCL high phase.
- R3: With gcEnable=0, a first byte of 0x00 is matched only against the own address. With a nonzero own address it is not acknowledged, no flag changes except those set by the Start, and no interrupt is raised.
- R4: With tenBitMode=0, a byte whose bits 7..1 equal ownAddr is acknowledged. Then gcFlag=0, dataFlag=0 and rwFlag equals byte bit 0 (1 = master reads). Any other unmatched byte is not acknowledged and rwFlag keeps its value.
- R5: On a general call match, gcFlag becomes 1 and both dataFlag and rwFlag become 0.
- R6: On a match, rxByte holds the received byte and rxFull is 1 before SCL falls at the end of the eighth bit. On no match, rxByte and rxFull are not loaded.
- R7: On a match, irqPulse is high for exactly one cycle after the ninth SCL falling edge, and never before it. sdaDriveLow is released at the same time. No interrupt follows a byte that was not acknowledged.
- R8: With tenBitMode=1, the 7-bit own-address compare is disabled (no acknowledge), while 0x00 with gcEnable=1 is still acknowledged as a general call.
- R9: A Stop or a repeated Start during the address byte abandons it without acknowledge or interrupt; after a repeated Start a fresh byte is received. Every Start clears gcFlag and sets dataFlag to 1.
- R10: A one-cycle rxRead pulse clears rxFull; a capture in the same cycle takes priority.
- R11: After reset: sdaDriveLow=0, irqPulse=0, rxFull=0, gcFlag=0, rwFlag=0, dataFlag=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen on the pad |
| sdaIn | input | 1 | Bus data line as seen on the pad |
| ownAddr | input | 7 | Programmable 7-bit slave address |
| gcEnable | input | 1 | 1 = recognize the general call byte 0x00 |
| tenBitMode | input | 1 | 1 = slave set for 10-bit addressing; 7-bit own compare off |
| rxRead | input | 1 | One-cycle strobe that clears rxFull |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls the data line low (ACK) |
| rxByte | output | 8 | Receive buffer |
| rxFull | output | 1 | Receive buffer holds an unread byte |
| gcFlag | output | 1 | Last match was a general call |
| dataFlag | output | 1 | 0 = last captured byte was an address |
| rwFlag | output | 1 | Direction of the addressed transfer, 1 = read |
| irqPulse | output | 1 | One-cycle slave interrupt |

## Verification
A wrong bit counter or state shows up within the same byte. The acknowledge either appears on the wrong clock or never appears during the ninth clock high phase, and the interrupt arrives early, late or not at all, all visible within a few bus clocks. A wrong compare or enable decision shows as a mismatched acknowledge and buffer-full value at the end of that same address byte. Stale flags after a Start or an abort are exposed by the first flag read that follows, before the next address byte completes.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_SETUP,
    ST_ACK_HOLD,
    ST_WAIT
  } addrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearShift;
    logic shiftEn;
    logic capture;
  } ctrlStrobe_t;

  // bus events and compare results from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic gcHit;
    logic ownHit;
  } busEvent_t;

endpackage

// File: rtl/i2c_addr_dpath.sv
module i2c_addr_dpath
  import i2c_addr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              gcEnable,
  input  logic              tenBitMode,
  input  logic              rxRead,
  input  ctrlStrobe_t       strobe,
  output busEvent_t         evt,
  output logic [ADDR_W:0]   rxByte,
  output logic              rxFull,
  output logic              gcFlag,
  output logic              dataFlag,
  output logic              rwFlag
);

  localparam int BYTE_W = ADDR_W + 1;

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic                   sclS, sdaS, sclPrev, sdaPrev;
  logic [BYTE_W-1:0]      shiftReg;
  logic [BYTE_W-1:0]      nextByte;
  logic                   gcHit, ownHit, anyHit;

  // synchronizers, idle bus reads high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  assign evt.sclRise   = sclS & ~sclPrev;
  assign evt.sclFall   = ~sclS & sclPrev;
  assign evt.startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
  assign evt.stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;

  // byte as it will be once the current sample is shifted in
  assign nextByte = {shiftReg[BYTE_W-2:0], sdaS};
  assign gcHit    = gcEnable && (nextByte == '0);
  assign ownHit   = !gcHit && !tenBitMode && (nextByte[BYTE_W-1:1] == ownAddr);
  assign anyHit   = gcHit | ownHit;

  assign evt.gcHit  = gcHit;
  assign evt.ownHit = ownHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.clearShift) begin
      shiftReg <= '0;
    end else if (strobe.shiftEn) begin
      shiftReg <= nextByte;
    end
  end

  // receive buffer; capture wins over a read in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      rxFull <= 1'b0;
    end else if (strobe.capture && anyHit) begin
      rxByte <= nextByte;
      rxFull <= 1'b1;
    end else if (rxRead) begin
      rxFull <= 1'b0;
    end
  end

  // status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gcFlag   <= 1'b0;
      dataFlag <= 1'b1;
      rwFlag   <= 1'b0;
    end else if (strobe.clearShift) begin
      gcFlag   <= 1'b0;
      dataFlag <= 1'b1;
    end else if (strobe.capture && anyHit) begin
      gcFlag   <= gcHit;
      dataFlag <= 1'b0;
      rwFlag   <= gcHit ? 1'b0 : nextByte[0];
    end
  end

endmodule

// File: rtl/i2c_addr_ctrl.sv
module i2c_addr_ctrl
  import i2c_addr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  busEvent_t   evt,
  output ctrlStrobe_t strobe,
  output logic        sdaDriveLow,
  output logic        irqPulse
);

  localparam int BITCNT_W = $clog2(BYTE_W);
  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);

  addrState_t          state, nextState;
  logic [BITCNT_W-1:0] bitCnt;
  logic                busReset;

  assign busReset = evt.startSeen | evt.stopSeen;

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (evt.startSeen) begin
      nextState         = ST_ADDR;
      strobe.clearShift = 1'b1;
    end else if (evt.stopSeen) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: begin
          if (evt.sclRise) begin
            strobe.shiftEn = 1'b1;
            if (bitCnt == LAST_BIT) begin
              strobe.capture = 1'b1;
              nextState = (evt.gcHit || evt.ownHit) ? ST_ACK_SETUP : ST_IDLE;
            end
          end
        end
        ST_ACK_SETUP: if (evt.sclFall) nextState = ST_ACK_HOLD;
        ST_ACK_HOLD:  if (evt.sclFall) nextState = ST_WAIT;
        default:      nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      sdaDriveLow <= 1'b0;
      irqPulse    <= 1'b0;
    end else begin
      state    <= nextState;
      irqPulse <= 1'b0;
      if (evt.startSeen) begin
        bitCnt <= '0;
      end else if (strobe.shiftEn) begin
        bitCnt <= bitCnt + 1'b1;
      end
      if (busReset) begin
        sdaDriveLow <= 1'b0;
      end else if (state == ST_ACK_SETUP && evt.sclFall) begin
        sdaDriveLow <= 1'b1;
      end else if (state == ST_ACK_HOLD && evt.sclFall) begin
        sdaDriveLow <= 1'b0;
        irqPulse    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer
  import i2c_addr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              gcEnable,
  input  logic              tenBitMode,
  input  logic              rxRead,
  output logic              sdaDriveLow,
  output logic [ADDR_W:0]   rxByte,
  output logic              rxFull,
  output logic              gcFlag,
  output logic              dataFlag,
  output logic              rwFlag,
  output logic              irqPulse
);

  ctrlStrobe_t strobe;
  busEvent_t   evt;

  i2c_addr_dpath #(
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .ownAddr    (ownAddr),
    .gcEnable   (gcEnable),
    .tenBitMode (tenBitMode),
    .rxRead     (rxRead),
    .strobe     (strobe),
    .evt        (evt),
    .rxByte     (rxByte),
    .rxFull     (rxFull),
    .gcFlag     (gcFlag),
    .dataFlag   (dataFlag),
    .rwFlag     (rwFlag)
  );

  i2c_addr_ctrl #(
    .BYTE_W (ADDR_W + 1)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .evt         (evt),
    .strobe      (strobe),
    .sdaDriveLow (sdaDriveLow),
    .irqPulse    (irqPulse)
  );

endmodule

// File: rtl/i2c_addr_checker.sv
module i2c_addr_checker (
  input logic clk,
  input logic rstN,
  input logic gcEnable,
  input logic sdaDriveLow,
  input logic irqPulse,
  input logic gcFlag,
  input logic dataFlag,
  input logic rwFlag
);

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R7

  AST_IRQ_ENDS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPulse) |-> ($past(sdaDriveLow) && !sdaDriveLow)); // R7

  AST_GC_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    gcFlag |-> (!rwFlag && !dataFlag)); // R5

  AST_GC_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gcFlag) |-> $past(gcEnable)); // R3

  AST_ACK_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !dataFlag); // R4

endmodule

bind i2c_addr_recognizer i2c_addr_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .gcEnable    (gcEnable),
  .sdaDriveLow (sdaDriveLow),
  .irqPulse    (irqPulse),
  .gcFlag      (gcFlag),
  .dataFlag    (dataFlag),
  .rwFlag      (rwFlag)
);

// File: tb/i2c_addr_recognizer_bench.sv
module i2c_addr_recognizer_bench;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rstN, mScl, mSda, gcEnable, tenBitMode, rxRead;
  logic [6:0] ownAddr;
  logic       sdaDriveLow, rxFull, gcFlag, dataFlag, rwFlag, irqPulse;
  logic [7:0] rxByte;
  logic       sdaBus;
  int         nRun = 0, nFail = 0, irqCount = 0;
  logic       expRw = 1'b0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  assign sdaBus = mSda & ~sdaDriveLow;

  i2c_addr_recognizer u_i2c_addr_recognizer (
    .clk (clk), .rstN (rstN), .sclIn (mScl), .sdaIn (sdaBus),
    .ownAddr (ownAddr), .gcEnable (gcEnable), .tenBitMode (tenBitMode),
    .rxRead (rxRead), .sdaDriveLow (sdaDriveLow), .rxByte (rxByte),
    .rxFull (rxFull), .gcFlag (gcFlag), .dataFlag (dataFlag),
    .rwFlag (rwFlag), .irqPulse (irqPulse)
  );

  always @(posedge clk) if (irqPulse) irqCount <= irqCount + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  function automatic bit isGc(input logic [7:0] b);
    return gcEnable && (b == 8'h00);
  endfunction

  function automatic bit isOwn(input logic [7:0] b);
    return !isGc(b) && !tenBitMode && (b[7:1] == ownAddr);
  endfunction

  function automatic string tagFor(input logic [7:0] b);
    if (isGc(b) && tenBitMode) return "R8";
    if (isGc(b)) return "R2";
    if (isOwn(b)) return "R4";
    if (tenBitMode) return "R8";
    if (b == 8'h00) return "R3";
    return "R1";
  endfunction

  task automatic startCond();
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ(); waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mSda = b[i]; waitQ();
      mScl = 1'b1; waitQ(); waitQ();
      mScl = 1'b0; waitQ();
    end
  endtask

  task automatic pulseRead();
    rxRead = 1'b1; @(negedge clk);
    rxRead = 1'b0; @(negedge clk);
  endtask

  task automatic runAddr(input logic [7:0] b);
    bit    gc, hit;
    int    base;
    string tg;
    gc  = isGc(b);
    hit = gc || isOwn(b);
    tg  = tagFor(b);
    pulseRead();
    startCond();
    base = irqCount;
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitQ();
      mScl = 1'b1; waitQ(); waitQ();
      if (i == 0) begin
        chk("R6", "rxFull at end of 8th bit", rxFull, hit);
        if (hit) chk("R6", "rxByte", rxByte, b);
      end
      mScl = 1'b0; waitQ();
    end
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    chk(tg, "ack during 9th clock", sdaDriveLow, hit);
    chk("R7", "no irq before 9th fall", irqCount - base, 0);
    waitQ();
    mScl = 1'b0; waitQ();
    chk("R7", "irq count after 9th fall", irqCount - base, hit);
    chk("R7", "ack released", sdaDriveLow, 0);
    if (hit) expRw = gc ? 1'b0 : b[0];
    chk(gc ? "R5" : "R4", "gcFlag", gcFlag, gc);
    chk(hit ? "R5" : "R9", "dataFlag", dataFlag, !hit);
    chk(gc ? "R5" : "R4", "rwFlag", rwFlag, expRw);
    stopCond();
    if (hit) begin
      chk("R6", "rxFull held", rxFull, 1);
      pulseRead();
      chk("R10", "rxFull cleared by read", rxFull, 0);
    end
  endtask

  initial begin
    rstN = 1'b0; mScl = 1'b1; mSda = 1'b1; rxRead = 1'b0;
    gcEnable = 1'b0; tenBitMode = 1'b0; ownAddr = 7'h2A;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11", "reset sdaDriveLow", sdaDriveLow, 0);
    chk("R11", "reset irqPulse", irqPulse, 0);
    chk("R11", "reset rxFull", rxFull, 0);
    chk("R11", "reset gcFlag", gcFlag, 0);
    chk("R11", "reset rwFlag", rwFlag, 0);
    chk("R11", "reset dataFlag", dataFlag, 1);

    // directed
    gcEnable = 1'b1; runAddr(8'h00);          // R2 R5
    gcEnable = 1'b0; runAddr(8'h00);          // R3
    runAddr(8'h55);                           // R4 read
    runAddr(8'h54);                           // R4 write
    runAddr(8'h56);                           // R1 mismatch
    gcEnable = 1'b1; runAddr(8'h00);
    startCond();                              // R9 start clears gc flag
    chk("R9", "gcFlag cleared by start", gcFlag, 0);
    chk("R9", "dataFlag set by start", dataFlag, 1);
    stopCond();
    tenBitMode = 1'b1; runAddr(8'h54);        // R8 no own match
    runAddr(8'h00);                           // R8 gc still works
    tenBitMode = 1'b0;

    // R9 abort by stop mid-byte
    pulseRead();
    begin
      int base;
      base = irqCount;
      startCond();
      sendBits(8'h54, 4);
      stopCond();
      chk("R9", "no irq after stop abort", irqCount - base, 0);
      chk("R9", "no capture after stop abort", rxFull, 0);
      chk("R9", "no ack after stop abort", sdaDriveLow, 0);
    end
    // R9 repeated start mid-byte then fresh address
    startCond();
    sendBits(8'h00, 3);
    runAddr(8'h55);

    // random
    for (int t = 0; t < 40; t++) begin
      logic [7:0] b;
      int sel;
      gcEnable   = ($urandom % 2) != 0;
      tenBitMode = ($urandom % 4) == 0;
      ownAddr    = 7'(1 + ($urandom % 127));
      sel = $urandom % 3;
      if (sel == 0) b = 8'h00;
      else if (sel == 1) b = {ownAddr, 1'($urandom % 2)};
      else b = 8'($urandom);
      runAddr(b);
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule